// File: doc/BRIEF.md
# Branch-Only Program-Flow Trace Encoder

The encoder watches a processor's retire interface and turns it into a compact byte stream for an external trace port. It emits nothing for instructions that fall through sequentially. Output appears only where control flow breaks (taken branches and exceptions) and at periodic synchronization points. A host decoder that holds the program image can rebuild the whole execution path from these few packets.

A taken-branch destination is sent as only the low bytes that differ from the last address the stream carried. Exceptions and synchronization packets carry a full address, so a decoder can lock on at any of them. Every packet can carry a timestamp delta with a programmable tick size. A 16-byte FIFO absorbs bursts between packet assembly and the byte-wide valid/ready output.

If the FIFO cannot take a whole packet, that packet is dropped and an overflow flag is raised. The next packet that fits is written as an overflow marker byte followed at once by a full-address sync.

Top module: `trc_flow_encoder`

## Requirements
- R1: A retire that is neither a taken branch nor an exception writes no bytes, unless a sync is due. This covers ordinary instructions, not-taken branches, and a taken flag without the branch flag.
- R2: A taken branch writes a header byte followed by n destination bytes, least significant first. The header holds the type 00 in bits [7:6], n in bits [5:3], the timestamp flag in bit [2] and zeros in bits [1:0]. n is one plus the index of the highest byte that differs from the last address the stream carried. n is 0 when the two addresses are equal.
- R3: An exception writes the type 01 header with n=4, then its full 32-bit destination. The destination becomes the new reference address.
- R4: The first retire after reset, or after trace_en_i rises, writes a sync packet. This is the type 10 header with n=4, then the full flow address: the destination if control transfers, otherwise the retire's own PC.
- R5: When sync_period_i is N≠0, every Nth retire counted since the last full-address packet becomes a sync packet. N=0 turns periodic sync off.
- R6: A packet that does not fit in the FIFO's free space is dropped and ovf_o goes high. Later packets are dropped until one fits together with a one-byte prefix. That write is the marker byte 0xC0 followed by a sync packet, after which ovf_o goes low.
- R7: With ts_en_i high, header bit [2] is set and two bytes follow the address, least significant first. They hold floor(cycles since the previous stamped packet / 2^ts_shift_i), saturating at 0xFFFF.
- R8: tb_valid_o stays high and tb_data_o stays stable while tb_ready_i is low. Bytes leave in the order they were written.
- R9: While trace_en_i is low, retires are ignored and no bytes are written.
- R10: After reset, tb_valid_o and ovf_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_en_i | input | 1 | Trace enable |
| sync_period_i | input | 16 | Retires between periodic syncs, 0 turns periodic sync off |
| ts_en_i | input | 1 | Append a timestamp delta to packets |
| ts_shift_i | input | 4 | Timestamp tick is 2^ts_shift_i cycles |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_pc_i | input | 32 | PC of the retiring instruction |
| ret_branch_i | input | 1 | Retiring instruction is a branch |
| ret_taken_i | input | 1 | The branch was taken |
| ret_exc_i | input | 1 | Retire enters an exception |
| ret_target_i | input | 32 | Branch target or exception handler address |
| tb_data_o | output | 8 | Trace byte |
| tb_valid_o | output | 1 | Trace byte valid |
| tb_ready_i | input | 1 | Sink accepts the byte |
| ovf_o | output | 1 | Packets have been lost and a marker is pending |

## Verification
The hardest state to reach from the ports is overflow recovery. The FIFO must be left with too little room for the next packet but not empty, and then drained before the marker and sync can appear. The stimulus holds tb_ready_i low and sends taken branches that alternate between 0xAAAAAAAA and 0x55555555. Every byte differs between these addresses, so each packet is exactly five bytes. Three such packets leave one free byte, which no following packet can use. The bench then releases the sink and checks the exact byte order: the three kept packets, then the marker, then the sync. The relative branch after that sync confirms that the reference address was updated.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    PK_BR   = 2'b00,
    PK_EXC  = 2'b01,
    PK_SYNC = 2'b10,
    PK_OVF  = 2'b11
  } pkt_kind_e;

  localparam logic [7:0] OVF_BYTE = {PK_OVF, 6'b000000};
endpackage

// File: rtl/trc_ts_unit.sv
module trc_ts_unit #(
  parameter int TS_W = 16,
  parameter int SH_W = 4,
  localparam int PRE_W = (1 << SH_W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SH_W-1:0] shift_i,
  input  logic            clear_i,
  output logic [TS_W-1:0] stamp_o
);
  logic [PRE_W-1:0] pre_q, mask;
  logic [TS_W-1:0]  delta_q;
  logic             tick, sat;

  // shift of PRE_W wraps the 1 out; minus one still yields all ones
  assign mask = (PRE_W'(1) << shift_i) - PRE_W'(1);
  assign tick = (pre_q == mask);
  assign sat  = (delta_q == '1);
  assign stamp_o = (tick && !sat) ? delta_q + TS_W'(1) : delta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      delta_q <= '0;
    end else if (clear_i) begin
      pre_q   <= '0;
      delta_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick && !sat) delta_q <= delta_q + TS_W'(1);
    end
  end

  assert_ts_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (delta_q == '0 && pre_q == '0));
endmodule

// File: rtl/trc_pkt_build.sv
module trc_pkt_build
  import trc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TS_W = 16,
  localparam int ADDR_B = ADDR_W / 8,
  localparam int TS_B = TS_W / 8,
  localparam int MAX_LEN = 2 + ADDR_B + TS_B,
  localparam int DW = 8 * MAX_LEN,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  pkt_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ref_i,
  input  logic              ovf_i,
  input  logic              ts_en_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic [DW-1:0]     data_o,
  output logic [LEN_W-1:0]  len_o
);
  always_comb begin
    int nb;
    int p;
    logic [7:0] hdr;
    logic [DW-1:0] acc;
    nb = ADDR_B;
    if (kind_i == PK_BR) begin
      nb = 0;
      for (int b = 0; b < ADDR_B; b++)
        if (addr_i[8*b+:8] != ref_i[8*b+:8]) nb = b + 1;
    end
    acc = '0;
    p   = 0;
    if (ovf_i) begin
      acc[7:0] = OVF_BYTE;
      p = 1;
    end
    hdr = {kind_i, 3'(nb), ts_en_i, 2'b00};
    acc = acc | (DW'(hdr) << (8 * p));
    p = p + 1;
    for (int b = 0; b < ADDR_B; b++) begin
      if (b < nb) begin
        acc = acc | (DW'(addr_i[8*b+:8]) << (8 * p));
        p = p + 1;
      end
    end
    if (ts_en_i) begin
      for (int t = 0; t < TS_B; t++) begin
        acc = acc | (DW'(ts_i[8*t+:8]) << (8 * p));
        p = p + 1;
      end
    end
    data_o = acc;
    len_o  = LEN_W'(p);
  end
endmodule

// File: rtl/trc_byte_fifo.sv
module trc_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int MAX_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [LEN_W-1:0]   wr_len_i,
  input  logic [8*MAX_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]   free_o,
  output logic [7:0]         rd_data_o,
  output logic               rd_valid_o,
  input  logic               rd_ready_i
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             pop;

  assign rd_valid_o = (count_q != '0);
  assign rd_data_o  = mem[rd_ptr_q];
  assign pop        = rd_valid_o && rd_ready_i;
  assign free_o     = CNT_W'(DEPTH) - count_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i)
      for (int i = 0; i < MAX_W; i++)
        if (i < int'(wr_len_i)) mem[wr_ptr_q + PTR_W'(i)] <= wr_data_i[8*i+:8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + PTR_W'(wr_len_i);
      if (pop) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      count_q <= count_q + (wr_en_i ? CNT_W'(wr_len_i) : CNT_W'(0)) - CNT_W'(pop);
    end
  end

  assert_fit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_len_i) <= int'(free_o)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
endmodule

// File: rtl/trc_flow_encoder.sv
module trc_flow_encoder
  import trc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TS_W = 16,
  parameter int SH_W = 4,
  parameter int PER_W = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int MAX_LEN = 2 + ADDR_W / 8 + TS_W / 8,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_en_i,
  input  logic [PER_W-1:0]  sync_period_i,
  input  logic              ts_en_i,
  input  logic [SH_W-1:0]   ts_shift_i,
  input  logic              ret_valid_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic              ret_branch_i,
  input  logic              ret_taken_i,
  input  logic              ret_exc_i,
  input  logic [ADDR_W-1:0] ret_target_i,
  output logic [7:0]        tb_data_o,
  output logic              tb_valid_o,
  input  logic              tb_ready_i,
  output logic              ovf_o
);
  logic               need_sync_q, ovf_q;
  logic [ADDR_W-1:0]  last_q, dest;
  logic [PER_W-1:0]   icnt_q;
  logic               ret_ok, jump, periodic, want, fits, fifo_wr;
  pkt_kind_e          kind;
  logic [8*MAX_LEN-1:0] pkt_data;
  logic [LEN_W-1:0]   pkt_len;
  logic [CNT_W-1:0]   free;
  logic [TS_W-1:0]    stamp;

  assign ret_ok   = ret_valid_i && trace_en_i;
  assign jump     = ret_exc_i || (ret_branch_i && ret_taken_i);
  assign dest     = jump ? ret_target_i : ret_pc_i;
  assign periodic = (sync_period_i != '0) && (icnt_q >= sync_period_i - PER_W'(1));

  always_comb begin
    want = 1'b0;
    kind = PK_SYNC;
    if (ret_ok) begin
      if (need_sync_q || ovf_q) begin
        want = 1'b1;
      end else if (ret_exc_i) begin
        want = 1'b1;
        kind = PK_EXC;
      end else if (periodic) begin
        want = 1'b1;
      end else if (ret_branch_i && ret_taken_i) begin
        want = 1'b1;
        kind = PK_BR;
      end
    end
  end

  assign fits    = int'(pkt_len) <= int'(free);
  assign fifo_wr = want && fits;
  assign ovf_o   = ovf_q;

  trc_pkt_build #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_build (
    .kind_i  (kind),
    .addr_i  (dest),
    .ref_i   (last_q),
    .ovf_i   (ovf_q),
    .ts_en_i (ts_en_i),
    .ts_i    (stamp),
    .data_o  (pkt_data),
    .len_o   (pkt_len)
  );

  trc_ts_unit #(.TS_W(TS_W), .SH_W(SH_W)) u_ts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (ts_shift_i),
    .clear_i (fifo_wr && ts_en_i),
    .stamp_o (stamp)
  );

  trc_byte_fifo #(.DEPTH(FIFO_DEPTH), .MAX_W(MAX_LEN)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (fifo_wr),
    .wr_len_i   (pkt_len),
    .wr_data_i  (pkt_data),
    .free_o     (free),
    .rd_data_o  (tb_data_o),
    .rd_valid_o (tb_valid_o),
    .rd_ready_i (tb_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      need_sync_q <= 1'b1;
      ovf_q       <= 1'b0;
      last_q      <= '0;
      icnt_q      <= '0;
    end else if (!trace_en_i) begin
      need_sync_q <= 1'b1;
      icnt_q      <= '0;
    end else begin
      if (fifo_wr) begin
        need_sync_q <= 1'b0;
        ovf_q       <= 1'b0;
        last_q      <= dest;
      end else if (want) begin
        ovf_q <= 1'b1;
      end
      if (fifo_wr && kind != PK_BR) icnt_q <= '0;
      else if (ret_ok && icnt_q != '1) icnt_q <= icnt_q + PER_W'(1);
    end
  end

  assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trace_en_i |-> !fifo_wr);
  assert_first_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr && need_sync_q && !ovf_q) |-> (pkt_data[7:6] == PK_SYNC));
  assert_ovf_prefix_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr && ovf_q) |-> (pkt_data[7:0] == OVF_BYTE && pkt_data[15:14] == PK_SYNC));
  assert_ovf_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want && !fits) |=> ovf_o);
endmodule

// File: tb/trc_flow_encoder_tb.sv
module trc_flow_encoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0;
  logic [15:0] period = '0;
  logic        ts_en = 1'b0;
  logic [3:0]  ts_shift = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_pc = '0;
  logic        ret_branch = 1'b0;
  logic        ret_taken = 1'b0;
  logic        ret_exc = 1'b0;
  logic [31:0] ret_target = '0;
  logic [7:0]  tb_data;
  logic        tb_valid;
  logic        tb_ready = 1'b1;
  logic        ovf;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] got [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  trc_flow_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trace_en_i(trace_en), .sync_period_i(period),
    .ts_en_i(ts_en), .ts_shift_i(ts_shift), .ret_valid_i(ret_valid), .ret_pc_i(ret_pc),
    .ret_branch_i(ret_branch), .ret_taken_i(ret_taken), .ret_exc_i(ret_exc),
    .ret_target_i(ret_target), .tb_data_o(tb_data), .tb_valid_o(tb_valid),
    .tb_ready_i(tb_ready), .ovf_o(ovf)
  );

  always @(negedge clk) if (rst_n && tb_valid && tb_ready) got.push_back(tb_data);

  typedef struct packed {
    logic br; logic tk; logic ex;
    logic [31:0] pc; logic [31:0] tgt;
    logic [3:0] n; logic [63:0] exp;
  } vec_t;

  // expected bytes stored least significant first
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 32'h1000,     32'h0,        4'd5, 64'h00000000001000A0},
    '{1'b0, 1'b0, 1'b0, 32'h1004,     32'h0,        4'd0, 64'h0},
    '{1'b1, 1'b0, 1'b0, 32'h1008,     32'h2000,     4'd0, 64'h0},
    '{1'b1, 1'b1, 1'b0, 32'h100C,     32'h1040,     4'd2, 64'h4008},
    '{1'b1, 1'b1, 1'b0, 32'h1040,     32'h1234,     4'd3, 64'h123410},
    '{1'b1, 1'b1, 1'b0, 32'h1234,     32'h00AB1234, 4'd4, 64'hAB123418},
    '{1'b1, 1'b1, 1'b0, 32'h00AB1234, 32'h80AB1234, 4'd5, 64'h80AB123420},
    '{1'b1, 1'b1, 1'b0, 32'h80AB1234, 32'h80AB1234, 4'd1, 64'h00},
    '{1'b0, 1'b0, 1'b1, 32'h80AB1234, 32'h00000100, 4'd5, 64'h0000010060},
    '{1'b1, 1'b1, 1'b0, 32'h100,      32'h108,      4'd2, 64'h0808},
    '{1'b0, 1'b1, 1'b0, 32'h10C,      32'h500,      4'd0, 64'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic retire(input logic br, input logic tk, input logic ex,
                        input logic [31:0] pc, input logic [31:0] tgt);
    ret_valid = 1'b1; ret_branch = br; ret_taken = tk; ret_exc = ex;
    ret_pc = pc; ret_target = tgt;
    @(posedge clk); #1;
    ret_valid = 1'b0; ret_branch = 1'b0; ret_taken = 1'b0; ret_exc = 1'b0;
  endtask

  task automatic expect_pkt(input string req, input int n, input logic [63:0] exp,
                            input logic [63:0] mask);
    logic [63:0] act;
    int have;
    act = '0;
    have = got.size();
    for (int i = 0; i < n; i++) if (got.size() > 0) act[8*i+:8] = got.pop_front();
    chk(have >= n && (act & mask) == (exp & mask), req, act, exp);
  endtask

  task automatic expect_none(input string req);
    chk(got.size() == 0, req, 64'(got.size()), 64'd0);
    got.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(tb_valid == 1'b0, "R10 valid after reset", 64'(tb_valid), 64'd0);
    chk(ovf == 1'b0, "R10 ovf after reset", 64'(ovf), 64'd0);

    // table: startup sync, relative branches, exception, silent retires
    trace_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      retire(VEC[v].br, VEC[v].tk, VEC[v].ex, VEC[v].pc, VEC[v].tgt);
      idle(8);
      if (VEC[v].n == 0) expect_none($sformatf("R1 vector %0d", v));
      else expect_pkt($sformatf("R2/R3/R4 vector %0d", v), int'(VEC[v].n), VEC[v].exp, '1);
    end

    // R9: disabled trace ignores retires
    trace_en = 1'b0;
    retire(1'b1, 1'b1, 1'b0, 32'h300, 32'h4000);
    idle(8);
    expect_none("R9 disabled");

    // R4 and R5: restart sync and periodic sync every 3rd retire
    trace_en = 1'b1; period = 16'd3;
    retire(1'b0, 1'b0, 1'b0, 32'h2000, 32'h0);
    retire(1'b0, 1'b0, 1'b0, 32'h2004, 32'h0);
    retire(1'b0, 1'b0, 1'b0, 32'h2008, 32'h0);
    retire(1'b0, 1'b0, 1'b0, 32'h200C, 32'h0);
    retire(1'b1, 1'b1, 1'b0, 32'h2010, 32'h2100);
    idle(20);
    expect_pkt("R4 sync after enable", 5, 64'h00002000A0, '1);
    expect_pkt("R5 periodic sync", 5, 64'h0000200CA0, '1);
    expect_pkt("R2 branch after sync", 3, 64'h210010, '1);
    expect_none("R1 no extra bytes");

    // R4: taken branch as first retire after enable carries its target
    trace_en = 1'b0; period = 16'd0;
    idle(2);
    trace_en = 1'b1;
    retire(1'b1, 1'b1, 1'b0, 32'h2200, 32'h7700);
    idle(10);
    expect_pkt("R4 sync with target", 5, 64'h00007700A0, '1);

    // R7: timestamp deltas
    ts_en = 1'b1; ts_shift = 4'd0;
    retire(1'b1, 1'b1, 1'b0, 32'h7700, 32'h7710);
    idle(4);
    retire(1'b1, 1'b1, 1'b0, 32'h7710, 32'h7720);
    idle(12);
    expect_pkt("R7 first stamped header", 4, 64'h100C, 64'hFFFF);
    expect_pkt("R7 delta 5 cycles", 4, 64'h0005200C, '1);
    ts_shift = 4'd2;
    retire(1'b1, 1'b1, 1'b0, 32'h7720, 32'h7730);
    idle(8);
    retire(1'b1, 1'b1, 1'b0, 32'h7730, 32'h7740);
    idle(12);
    expect_pkt("R7 shift header", 4, 64'h300C, 64'hFFFF);
    expect_pkt("R7 delta 9 cycles shift 2", 4, 64'h0002400C, '1);
    ts_en = 1'b0; ts_shift = 4'd0;

    // R6 and R8: fill FIFO with the sink stalled, lose packets, recover
    tb_ready = 1'b0;
    retire(1'b1, 1'b1, 1'b0, 32'h7740, 32'hAAAAAAAA);
    retire(1'b1, 1'b1, 1'b0, 32'hAAAAAAAA, 32'h55555555);
    retire(1'b1, 1'b1, 1'b0, 32'h55555555, 32'hAAAAAAAA);
    chk(tb_valid == 1'b1 && tb_data == 8'h20, "R8 head byte while stalled",
        {55'd0, tb_valid, tb_data}, {55'd0, 1'b1, 8'h20});
    retire(1'b1, 1'b1, 1'b0, 32'hAAAAAAAA, 32'h55555555);
    chk(ovf == 1'b1, "R6 overflow flag", 64'(ovf), 64'd1);
    retire(1'b1, 1'b1, 1'b0, 32'h55555555, 32'h12345678);
    idle(3);
    chk(tb_valid == 1'b1 && tb_data == 8'h20, "R8 stable while stalled",
        {55'd0, tb_valid, tb_data}, {55'd0, 1'b1, 8'h20});
    tb_ready = 1'b1;
    idle(30);
    chk(ovf == 1'b1, "R6 flag held until write", 64'(ovf), 64'd1);
    retire(1'b0, 1'b0, 1'b0, 32'h3000, 32'h0);
    chk(ovf == 1'b0, "R6 flag cleared", 64'(ovf), 64'd0);
    retire(1'b1, 1'b1, 1'b0, 32'h3004, 32'h3008);
    idle(20);
    expect_pkt("R8 order pkt 1", 5, 64'hAAAAAAAA20, '1);
    expect_pkt("R8 order pkt 2", 5, 64'h5555555520, '1);
    expect_pkt("R8 order pkt 3", 5, 64'hAAAAAAAA20, '1);
    expect_pkt("R6 marker then sync", 6, 64'h00003000A0C0, '1);
    expect_pkt("R2 branch relative to sync", 2, 64'h0808, '1);
    expect_none("R6 dropped packets absent");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule